// File: doc/BRIEF.md
# CEC Transmit Staging and Retry Controller

This block is the transmit half of a consumer-electronics-control (CEC) controller as software sees it. Software stages a frame through a small byte-wide register port: a 4-bit initiator address, a 4-bit destination address, an opcode and up to `MAX_OPERANDS` operand bytes. A frame starts in one of two ways. Writing the destination register with its poll flag set starts a header-only poll frame. Writing the transmit-data register with its go bit set starts a frame that carries an opcode, and the same write sets the operand count.

The block passes the staged frame to an external bit-level transmitter. It raises a one-cycle start pulse and then waits for a done pulse that carries a result code. When the transmitter reports no-acknowledge or lost arbitration, the block starts the same frame again, up to a programmed number of retries. After the last failed attempt it posts a failure status bit; after a success it posts a completion status. Status bits are write-one-to-clear, and per-bit enables mask them onto one interrupt line.

A control register also holds a self-clearing flush of the staged data. Two mask registers form a 16-bit logical-address claim vector for a neighbouring receiver.

Top module: `cec_tx_stage`

## Requirements
- R1: After reset every register reads 0x00, `tx_start` and `irq` are low and `la_mask` is 0x0000.
- R2: A write to the destination register (address 1) stores bits 3:0 as the destination and bit 7 as the poll flag. With bit 7 set while idle, `tx_start` pulses in the following cycle with `tx_poll`=1, and `tx_header` equals {initiator (address 0, bits 3:0), destination}.
- R3: A write to the transmit-data register (address 3) while idle stores bits 3:0 as the operand count, clamped to `MAX_OPERANDS`. When bit 4 is set, the same write also clears the poll flag and starts a frame, with `tx_opcode` from address 2 and operands from addresses 16 upwards. Without bit 4 the write starts nothing.
- R4: Each attempt raises `tx_start` for exactly one cycle. After a done pulse with `tx_result` other than 0 (0 = acknowledged, 1 = arbitration lost, 2 or 3 = not acknowledged), the next attempt's `tx_start` comes in the cycle after that done pulse, provided retries remain.
- R5: Bits 6:4 of the control register (address 4) hold the retry limit, equal to the number of attempts minus one. When the last allowed attempt fails, status register 1 (address 6) sets bit 1 for not-acknowledged or bit 0 for arbitration lost, and the control field still reads the limit, which equals the retries consumed.
- R6: An acknowledged attempt ends the frame and sets bits 5 and 2 (mask 0x24) of status register 0 (address 5).
- R7: Writing a 1 to a status bit clears it. A set and a clear of the same bit in the same cycle leave the bit set.
- R8: `irq` is high exactly when some status bit is set whose enable bit is set (address 7 for status 0, address 8 for status 1).
- R9: `la_mask` is {address 10, address 9}: address 9 covers logical addresses 0 to 7 and address 10 covers 8 to 15.
- R10: While an attempt sequence is active, or while a flush is in progress, writes to addresses 0 to 3 and to the operand registers are ignored, so a new start request is ignored too. While an attempt sequence is active, the retry field also ignores writes.
- R11: Writing bit 7 of the control register starts a flush. Bit 7 then reads 1 for `FLUSH_CYCLES` cycles and then 0. The flush clears the opcode, the operand count, the operands and the poll flag, and it abandons any frame in progress: no further `tx_start` is issued and no status bit is set.
- R12: A done pulse from the transmitter while no attempt is outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address, used for writes and for reads |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| tx_start | output | 1 | One-cycle start of an attempt |
| tx_poll | output | 1 | Frame is header-only |
| tx_header | output | 8 | {initiator, destination} |
| tx_opcode | output | 8 | Staged opcode |
| tx_op_cnt | output | 4 | Number of operand bytes |
| tx_operands | output | MAX_OPERANDS*8 | Operand bytes, operand 0 in the low byte |
| tx_done | input | 1 | Transmitter finished an attempt |
| tx_result | input | 2 | Attempt result: 0 acknowledged, 1 arbitration lost, 2 or 3 not acknowledged |
| irq | output | 1 | Masked status interrupt |
| la_mask | output | 16 | Logical-address claim vector |

## Verification
The bench runs each retry-limit case to the point where it is used up, once with not-acknowledged and once with arbitration lost. A design off by one would issue one attempt too many or too few, or would post the wrong failure bit. It sends start requests while a frame is in flight and checks that no extra start pulse and no staging change follow; a design without the lock would corrupt the header mid-frame. It also starts a flush during a pending retry and then sends a stray done pulse. A faulty design would either retry after the flush or post status from a done pulse it had no attempt outstanding for. An operand count above the maximum must come back clamped rather than wrapped.

// File: rtl/cec_tx_stage.sv
module cec_tx_stage #(
  parameter int MAX_OPERANDS = 14,
  parameter int FLUSH_CYCLES = 3,
  parameter int AW           = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic [AW-1:0]             reg_addr,
  input  logic [7:0]                reg_wdata,
  output logic [7:0]                reg_rdata,
  output logic                      tx_start,
  output logic                      tx_poll,
  output logic [7:0]                tx_header,
  output logic [7:0]                tx_opcode,
  output logic [3:0]                tx_op_cnt,
  output logic [MAX_OPERANDS*8-1:0] tx_operands,
  input  logic                      tx_done,
  input  logic [1:0]                tx_result,
  output logic                      irq,
  output logic [15:0]               la_mask
);

  localparam logic [AW-1:0] A_INIT = AW'(0);
  localparam logic [AW-1:0] A_DEST = AW'(1);
  localparam logic [AW-1:0] A_OPC  = AW'(2);
  localparam logic [AW-1:0] A_XMIT = AW'(3);
  localparam logic [AW-1:0] A_CTRL = AW'(4);
  localparam logic [AW-1:0] A_ST0  = AW'(5);
  localparam logic [AW-1:0] A_ST1  = AW'(6);
  localparam logic [AW-1:0] A_EN0  = AW'(7);
  localparam logic [AW-1:0] A_EN1  = AW'(8);
  localparam logic [AW-1:0] A_MLO  = AW'(9);
  localparam logic [AW-1:0] A_MHI  = AW'(10);
  localparam logic [AW-1:0] A_OPR  = AW'(16);
  localparam logic [AW-1:0] A_OEND = AW'(16 + MAX_OPERANDS);
  localparam int            IW     = (MAX_OPERANDS > 1) ? $clog2(MAX_OPERANDS) : 1;
  localparam int            FW     = $clog2(FLUSH_CYCLES + 1);
  localparam logic [3:0]    MAXC   = 4'(MAX_OPERANDS);

  typedef enum logic [1:0] {S_IDLE, S_START, S_WAIT} state_t;

  state_t     state;
  logic [3:0] init_q, dest_q, cnt_q;
  logic       poll_q;
  logic [7:0] opc_q, st0_q, st1_q, en0_q, en1_q, mlo_q, mhi_q;
  logic [7:0] opr_q [MAX_OPERANDS];
  logic [2:0] lim_q, used_q;
  logic [FW-1:0] fl_q;

  logic          busy, flushing, locked, flush_req, go, is_opr, in_wait;
  logic [3:0]    cnt_in;
  logic [IW-1:0] opr_idx;
  logic [7:0]    set0, set1, clr0, clr1;
  logic [AW-1:0] opr_off;

  assign busy      = (state != S_IDLE);
  assign in_wait   = (state == S_WAIT);
  assign flushing  = (fl_q != '0);
  assign locked    = busy || flushing;
  assign flush_req = reg_wr && reg_addr == A_CTRL && reg_wdata[7];
  assign go        = reg_wr && !locked &&
                     ((reg_addr == A_DEST && reg_wdata[7]) ||
                      (reg_addr == A_XMIT && reg_wdata[4]));
  assign cnt_in    = (reg_wdata[3:0] > MAXC) ? MAXC : reg_wdata[3:0];
  assign is_opr    = (reg_addr >= A_OPR) && (reg_addr < A_OEND);
  assign opr_off   = reg_addr - A_OPR;
  assign opr_idx   = opr_off[IW-1:0];
  assign clr0      = (reg_wr && reg_addr == A_ST0) ? reg_wdata : 8'h00;
  assign clr1      = (reg_wr && reg_addr == A_ST1) ? reg_wdata : 8'h00;

  always_comb begin
    set0 = 8'h00;
    set1 = 8'h00;
    if (in_wait && tx_done && !flush_req) begin
      if (tx_result == 2'd0)     set0 = 8'h24;
      else if (used_q >= lim_q)  set1 = (tx_result == 2'd1) ? 8'h01 : 8'h02;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      used_q <= '0;
    end else if (flush_req) begin
      state  <= S_IDLE;
    end else begin
      case (state)
        S_IDLE:  if (go) begin state <= S_START; used_q <= '0; end
        S_START: state <= S_WAIT;
        S_WAIT:  if (tx_done) begin
          if (tx_result != 2'd0 && used_q < lim_q) begin
            used_q <= used_q + 3'd1;
            state  <= S_START;
          end else begin
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= '0;
      dest_q <= '0;
      poll_q <= 1'b0;
      opc_q  <= '0;
      cnt_q  <= '0;
      lim_q  <= '0;
      fl_q   <= '0;
      for (int i = 0; i < MAX_OPERANDS; i++) opr_q[i] <= '0;
    end else begin
      if (flush_req)     fl_q <= FW'(FLUSH_CYCLES);
      else if (flushing) fl_q <= fl_q - FW'(1);
      if (reg_wr) begin
        if (reg_addr == A_CTRL) begin
          if (!busy) lim_q <= reg_wdata[6:4];
          if (reg_wdata[7]) begin
            opc_q  <= '0;
            cnt_q  <= '0;
            poll_q <= 1'b0;
            for (int i = 0; i < MAX_OPERANDS; i++) opr_q[i] <= '0;
          end
        end else if (!locked) begin
          case (reg_addr)
            A_INIT: init_q <= reg_wdata[3:0];
            A_DEST: begin dest_q <= reg_wdata[3:0]; poll_q <= reg_wdata[7]; end
            A_OPC:  opc_q <= reg_wdata;
            A_XMIT: begin cnt_q <= cnt_in; if (reg_wdata[4]) poll_q <= 1'b0; end
            default: if (is_opr) opr_q[opr_idx] <= reg_wdata;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st0_q <= '0;
      st1_q <= '0;
      en0_q <= '0;
      en1_q <= '0;
      mlo_q <= '0;
      mhi_q <= '0;
    end else begin
      st0_q <= (st0_q & ~clr0) | set0;
      st1_q <= (st1_q & ~clr1) | set1;
      if (reg_wr) begin
        if (reg_addr == A_EN0) en0_q <= reg_wdata;
        if (reg_addr == A_EN1) en1_q <= reg_wdata;
        if (reg_addr == A_MLO) mlo_q <= reg_wdata;
        if (reg_addr == A_MHI) mhi_q <= reg_wdata;
      end
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      A_INIT: reg_rdata = {4'h0, init_q};
      A_DEST: reg_rdata = {poll_q, 3'b000, dest_q};
      A_OPC:  reg_rdata = opc_q;
      A_XMIT: reg_rdata = {4'h0, cnt_q};
      A_CTRL: reg_rdata = {flushing, lim_q, 4'h0};
      A_ST0:  reg_rdata = st0_q;
      A_ST1:  reg_rdata = st1_q;
      A_EN0:  reg_rdata = en0_q;
      A_EN1:  reg_rdata = en1_q;
      A_MLO:  reg_rdata = mlo_q;
      A_MHI:  reg_rdata = mhi_q;
      default: if (is_opr) reg_rdata = opr_q[opr_idx];
    endcase
  end

  generate
    for (genvar g = 0; g < MAX_OPERANDS; g++) begin : g_opr
      assign tx_operands[g*8 +: 8] = opr_q[g];
    end
  endgenerate

  assign tx_start  = (state == S_START);
  assign tx_poll   = poll_q;
  assign tx_header = {init_q, dest_q};
  assign tx_opcode = opc_q;
  assign tx_op_cnt = cnt_q;
  assign irq       = |(st0_q & en0_q) || |(st1_q & en1_q);
  assign la_mask   = {mhi_q, mlo_q};

endmodule

module cec_tx_stage_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_start,
  input logic       tx_done,
  input logic [1:0] tx_result,
  input logic [7:0] st0,
  input logic [7:0] st1,
  input logic       flushing,
  input logic       in_wait,
  input logic [7:0] tx_header
);

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start); // R4

  AST_FLUSH_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |-> !tx_start); // R11

  AST_NACK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st1[1]) |-> $past(tx_done && tx_result[1])); // R5

  AST_ARB_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st1[0]) |-> $past(tx_done && tx_result == 2'd1)); // R5

  AST_ACK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st0[2]) |-> $past(tx_done && tx_result == 2'd0)); // R6

  AST_HEADER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> $stable(tx_header)); // R10

endmodule

bind cec_tx_stage cec_tx_stage_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_start  (tx_start),
  .tx_done   (tx_done),
  .tx_result (tx_result),
  .st0       (st0_q),
  .st1       (st1_q),
  .flushing  (flushing),
  .in_wait   (in_wait),
  .tx_header (tx_header)
);

// File: tb/tb_cec_tx_stage.sv
`timescale 1ns/1ps
module tb_cec_tx_stage;
  localparam int NOP = 14;
  localparam int FLC = 3;
  localparam int AW  = 5;
  localparam int DLY = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic tx_start, tx_poll, irq;
  logic [7:0] tx_header, tx_opcode;
  logic [3:0] tx_op_cnt;
  logic [NOP*8-1:0] tx_operands;
  logic tx_done = 1'b0;
  logic [1:0] tx_result = 2'd0;
  logic [15:0] la_mask;

  always #10 clk = ~clk;

  cec_tx_stage #(.MAX_OPERANDS(NOP), .FLUSH_CYCLES(FLC), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_start(tx_start),
    .tx_poll(tx_poll), .tx_header(tx_header), .tx_opcode(tx_opcode),
    .tx_op_cnt(tx_op_cnt), .tx_operands(tx_operands), .tx_done(tx_done),
    .tx_result(tx_result), .irq(irq), .la_mask(la_mask));

  int tests = 0, fails = 0, starts = 0, cycles = 0;
  bit valid = 0, stray = 0;
  int cd = 0;
  int resq[$];

  // reference model state
  int m_st, m_init, m_dest, m_poll, m_opc, m_cnt, m_lim, m_used, m_fl;
  int m_st0, m_st1, m_en0, m_en1, m_mlo, m_mhi;
  int m_opr [NOP];

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_read(int a);
    case (a)
      0: return m_init;
      1: return (m_poll << 7) | m_dest;
      2: return m_opc;
      3: return m_cnt;
      4: return ((m_fl > 0) << 7) | (m_lim << 4);
      5: return m_st0;
      6: return m_st1;
      7: return m_en0;
      8: return m_en1;
      9: return m_mlo;
      10: return m_mhi;
      default: return (a >= 16 && a < 16 + NOP) ? m_opr[a-16] : 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    if (a <= 1) return "R2";
    if (a <= 3 || a >= 16) return "R3";
    if (a == 4) return "R5";
    if (a == 5) return "R6";
    if (a == 6) return "R7";
    if (a <= 8) return "R8";
    return "R9";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_init = 0; m_dest = 0; m_poll = 0; m_opc = 0; m_cnt = 0;
      m_lim = 0; m_used = 0; m_fl = 0; m_st0 = 0; m_st1 = 0;
      m_en0 = 0; m_en1 = 0; m_mlo = 0; m_mhi = 0;
      foreach (m_opr[i]) m_opr[i] = 0;
      valid = 1;
    end else begin
      int a, d, nst, set0, set1, clr0, clr1;
      bit lock, busy, flreq, go;
      a = reg_addr; d = reg_wdata;
      busy = (m_st != 0);
      lock = busy || (m_fl > 0);
      flreq = reg_wr && a == 4 && d[7];
      set0 = 0; set1 = 0; clr0 = 0; clr1 = 0;
      nst = m_st;
      if (m_st == 1) nst = 2;
      else if (m_st == 2 && tx_done) begin
        if (tx_result == 0) begin nst = 0; if (!flreq) set0 = 'h24; end
        else if (m_used < m_lim) begin m_used++; nst = 1; end
        else begin nst = 0; if (!flreq) set1 = (tx_result == 1) ? 1 : 2; end
      end
      go = reg_wr && !lock && ((a == 1 && d[7]) || (a == 3 && d[4]));
      if (go) begin nst = 1; m_used = 0; end
      if (flreq) nst = 0;
      if (flreq) m_fl = FLC; else if (m_fl > 0) m_fl--;
      if (reg_wr) begin
        if (a == 4) begin
          if (!busy) m_lim = (d >> 4) & 7;
          if (d[7]) begin
            m_opc = 0; m_cnt = 0; m_poll = 0;
            foreach (m_opr[i]) m_opr[i] = 0;
          end
        end else if (a == 5) clr0 = d;
        else if (a == 6) clr1 = d;
        else if (a == 7) m_en0 = d;
        else if (a == 8) m_en1 = d;
        else if (a == 9) m_mlo = d;
        else if (a == 10) m_mhi = d;
        else if (!lock) begin
          if (a == 0) m_init = d & 15;
          else if (a == 1) begin m_dest = d & 15; m_poll = d[7]; end
          else if (a == 2) m_opc = d;
          else if (a == 3) begin
            m_cnt = ((d & 15) > NOP) ? NOP : (d & 15);
            if (d[4]) m_poll = 0;
          end else if (a >= 16 && a < 16 + NOP) m_opr[a-16] = d;
        end
      end
      m_st0 = (m_st0 & ~clr0) | set0;
      m_st1 = (m_st1 & ~clr1) | set1;
      m_st = nst;
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (valid) begin
      logic [NOP*8-1:0] eo;
      foreach (m_opr[i]) eo[i*8 +: 8] = 8'(m_opr[i]);
      chk("R4 tx_start", int'(tx_start), int'(m_st == 1));
      chk("R8 irq", int'(irq), int'(((m_st0 & m_en0) | (m_st1 & m_en1)) != 0));
      chk("R9 la_mask", int'(la_mask), (m_mhi << 8) | m_mlo);
      chk("R2 tx_header", int'(tx_header), (m_init << 4) | m_dest);
      chk("R2 tx_poll", int'(tx_poll), m_poll);
      chk("R3 tx_op_cnt", int'(tx_op_cnt), m_cnt);
      chk("R3 tx_opcode", int'(tx_opcode), m_opc);
      chk("R3 tx_operands", int'(tx_operands == eo), 1);
      chk({tag_of(int'(reg_addr)), " reg_rdata"}, int'(reg_rdata), m_read(int'(reg_addr)));
      if (tx_start) starts++;
    end
  end

  // bit-level transmitter stand-in
  always begin
    @(posedge clk); #1;
    tx_done = 1'b0;
    if (stray) begin tx_done = 1'b1; tx_result = 2'd2; stray = 0; end
    if (cd > 0) begin
      cd--;
      if (cd == 0) begin
        tx_done = 1'b1;
        tx_result = (resq.size() > 0) ? 2'(resq.pop_front()) : 2'd0;
      end
    end
    if (tx_start) cd = DLY;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected <=20000 cycles", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = 8'(d);
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, int exp, string tag);
    @(posedge clk); #1;
    reg_addr = AW'(a);
    @(negedge clk);
    chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    idle(2);
    @(posedge clk); #1 rst_n = 1'b1;
    rd(4, 8'h00, "R1 ctrl after reset");
    rd(5, 8'h00, "R1 status0 after reset");
    chk("R1 irq after reset", int'(irq), 0);
    chk("R1 la_mask after reset", int'(la_mask), 0);

    wr(7, 8'h24); wr(8, 8'h03);
    wr(9, 8'h11); wr(10, 8'h80);
    @(negedge clk);
    chk("R9 la_mask value", int'(la_mask), 16'h8011);

    // frame with opcode and three operands, acknowledged
    resq.delete(); starts = 0;
    wr(0, 4); wr(1, 5); wr(2, 8'h82);
    wr(16, 8'hA0); wr(17, 8'hA1); wr(18, 8'hA2);
    wr(3, 8'h13);
    idle(12);
    chk("R3 single start", starts, 1);
    rd(5, 8'h24, "R6 completion status");
    chk("R8 irq on completion", int'(irq), 1);
    chk("R2 header", int'(tx_header), 8'h45);
    wr(5, 8'h24);
    rd(5, 8'h00, "R7 status0 cleared");

    // retry limit 2, all not acknowledged
    resq.delete(); starts = 0;
    wr(4, 8'h20);
    resq = '{2, 2, 2};
    wr(3, 8'h10);
    idle(30);
    chk("R5 three attempts", starts, 3);
    rd(6, 8'h02, "R5 nack status");
    rd(4, 8'h20, "R5 retry field readback");
    wr(6, 8'h02);
    rd(6, 8'h00, "R7 status1 cleared");

    // arbitration lost then acknowledged, then lost twice
    resq.delete(); starts = 0;
    wr(4, 8'h10);
    resq = '{1, 0};
    wr(3, 8'h10);
    idle(25);
    chk("R4 retry after arbitration loss", starts, 2);
    rd(5, 8'h24, "R6 success after retry");
    rd(6, 8'h00, "R5 no failure posted");
    wr(5, 8'h24);
    starts = 0; resq = '{1, 1};
    wr(3, 8'h10);
    idle(25);
    chk("R5 two attempts", starts, 2);
    rd(6, 8'h01, "R5 arbitration status");
    wr(6, 8'h01);

    // poll frame
    resq.delete(); starts = 0;
    wr(1, 8'h85);
    idle(12);
    chk("R2 poll start", starts, 1);
    chk("R2 poll flag", int'(tx_poll), 1);
    chk("R2 poll header", int'(tx_header), 8'h45);
    wr(5, 8'h24);

    // count write without go bit
    starts = 0;
    wr(3, 8'h03);
    idle(8);
    chk("R3 no start without go", starts, 0);
    rd(3, 8'h03, "R3 count stored");

    // clamped count
    wr(3, 8'h1F);
    idle(12);
    chk("R3 clamp start", starts, 1);
    rd(3, NOP, "R3 count clamped");
    chk("R3 tx_op_cnt clamped", int'(tx_op_cnt), NOP);
    wr(5, 8'h24);

    // writes while busy are ignored
    starts = 0; resq.delete();
    wr(3, 8'h12);
    wr(2, 8'h55);
    wr(3, 8'h11);
    idle(12);
    chk("R10 one start only", starts, 1);
    rd(2, 8'h82, "R10 opcode kept");
    rd(3, 8'h02, "R10 count kept");
    wr(5, 8'h24);

    // flush during pending retries
    starts = 0;
    wr(4, 8'h30);
    resq = '{2, 2, 2, 2};
    wr(3, 8'h12);
    wr(4, 8'h80);
    rd(4, 8'hB0, "R11 flush in progress");
    idle(20);
    chk("R11 no retry after flush", starts, 1);
    rd(6, 8'h00, "R11 no failure posted");
    rd(2, 8'h00, "R11 opcode cleared");
    rd(16, 8'h00, "R11 operand cleared");
    rd(4, 8'h30, "R11 flush self-cleared");

    // stray done
    stray = 1;
    idle(4);
    rd(6, 8'h00, "R12 stray done ignored");
    rd(5, 8'h00, "R12 no completion");
    chk("R12 no start", starts, 1);

    idle(4);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule